// File: doc/BRIEF.md
# UART Receive FIFO and Status Controller

This block is the receive half of a serial port's data path, placed after a bit-level deserializer that has already framed each character. Every accepted byte goes into a 16-entry first-in first-out store. Software drains the store through a small register interface. Software also polls a set of status flags, or waits for a receive interrupt.

A threshold flag rises once the number of stored bytes reaches a programmable trigger count. The interrupt pulses on each rising edge of that flag. A character-time idle timer raises a data-ready flag when a short tail of bytes, below the trigger, has been left waiting. Error, break and overrun flags record problems reported with incoming bytes. Every flag clears only through a write of zero that follows a read of the same register which returned one. A synchronized copy of the raw receive line can be read so that software can tell a break apart from a framing error.

Register map (3-bit address):
- 0 is the data window; a read pops one byte.
- 1 is status: bit 0 threshold, bit 1 receive error, bit 2 break, bit 3 data ready.
- 2 is line status: bit 0 overrun, bit 7 line level.
- 3 is the fill count.
- 4 is control: bit 0 enable, bits 2:1 trigger select, bits 7:3 idle timeout in character times.

Top module: `uart_rx_fifo_status`

## Requirements
- R1: After reset, status, line-status bit 0, fill count, control and the interrupt all read 0.
- R2: While enabled, every byte strobed on `rx_valid` is stored. Reads of address 0 return the bytes in arrival order and remove one each. Address 3 reports the number of bytes held.
- R3: While control bit 0 is 0, strobed bytes are ignored: the count and the flags do not change.
- R4: The threshold flag (status bit 0) is set on the clock edge after the fill count reaches the trigger. Trigger select 00, 01, 10 and 11 means 1, 4, 8 and 14 bytes.
- R5: A write of 0 to a flag bit clears that flag only if a read of its register since the last write to that register returned 1. A zero write with no such read leaves the flag at 1. After a clear, the threshold flag is set again on the following edge if the count is still at or above the trigger.
- R6: `rxi` is high for exactly one cycle, the first cycle in which the threshold flag reads 1 after reading 0.
- R7: A byte accepted with a framing or parity error indication sets the receive error flag (status bit 1). A byte with the break indication sets status bit 2. Both clear under the rule of R5.
- R8: A byte that arrives while 16 bytes are held and none is being read is discarded and sets line-status bit 0. The stored bytes and the count are unchanged.
- R9: If the store holds at least one byte but fewer than the trigger, status bit 3 is set on the Nth `char_tick` after the last accepted byte, where N is the nonzero timeout field.
- R10: Line-status bit 7 shows the level of `rxd_line` two clock edges after it changes.
- R11: A read of address 0 while the store is empty returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | One-cycle strobe: a byte is ready from the deserializer |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | Framing error seen on this byte |
| rx_parity_err | input | 1 | Parity error seen on this byte |
| rx_break | input | 1 | Break condition seen on this byte |
| char_tick | input | 1 | One pulse per character time |
| rxd_line | input | 1 | Raw serial receive line |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| rxi | output | 1 | Receive interrupt pulse |

## Verification
Read data is combinational, so a register value is valid within the cycle its address is driven. A byte strobe, a pop, a control write or a flag clear takes effect on the next edge. The threshold flag and `rxi` follow one edge after the count changes, and the line level follows two edges after `rxd_line` changes. The bench drives every strobe for one cycle from a falling edge and samples at least one falling edge after the edge on which a result is due. For the clear-then-reassert case it samples at the falling edge directly between the two edges.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;

  typedef enum logic [2:0] {
    A_DATA  = 3'd0,
    A_STAT  = 3'd1,
    A_LINE  = 3'd2,
    A_COUNT = 3'd3,
    A_CTRL  = 3'd4
  } rxfs_addr_e;

  // trigger select code -> byte count
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxfs_fifo.sv
module rxfs_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = wr_q + 1'b1;
    if (pop)  rd_d = rd_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/rxfs_flag_cell.sv
module rxfs_flag_cell #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag,
  output logic clr
);
  logic flag_q, flag_d, armed_q, armed_d;

  assign clr = wr_stb & armed_q & ~wr_bit;

  generate
    if (SET_WINS) begin : g_set_wins
      always_comb flag_d = set | (flag_q & ~clr);
    end else begin : g_clr_wins
      always_comb flag_d = clr ? 1'b0 : (flag_q | set);
    end
  endgenerate

  always_comb begin
    armed_d = armed_q;
    if (wr_stb)                armed_d = 1'b0;
    else if (rd_stb && flag_q) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/rxfs_idle_timer.sv
module rxfs_idle_timer #(
  parameter int TMO_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [TMO_W-1:0] tmo,
  output logic             fire
);
  logic [TMO_W-1:0] idle_q, idle_d;

  always_comb begin
    idle_d = idle_q;
    if (restart)                        idle_d = '0;
    else if (tick && (idle_q != '1))    idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_d;
  end

  assign fire = tick & ~restart & (tmo != '0) & (idle_q == tmo - 1'b1);
endmodule

// File: rtl/uart_rx_fifo_status.sv
module uart_rx_fifo_status #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              rx_break,
  input  logic              char_tick,
  input  logic              rxd_line,
  input  logic [2:0]        reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rxi
);
  import rxfs_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int TMO_W = DATA_W - 3;

  // reset release synchronizer
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // control register
  logic             en_q, en_d;
  logic [1:0]       tsel_q, tsel_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             ctrl_wr;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

  always_comb begin
    en_d   = en_q;
    tsel_d = tsel_q;
    tmo_d  = tmo_q;
    if (ctrl_wr) begin
      en_d   = reg_wdata[0];
      tsel_d = reg_wdata[2:1];
      tmo_d  = reg_wdata[DATA_W-1:3];
    end
  end

  // line level synchronizer and threshold history
  logic rxd_s1, rxd_s2, rdf, rdf_prev_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q       <= 1'b0;
      tsel_q     <= 2'd0;
      tmo_q      <= '0;
      rxd_s1     <= 1'b1;
      rxd_s2     <= 1'b1;
      rdf_prev_q <= 1'b0;
    end else begin
      en_q       <= en_d;
      tsel_q     <= tsel_d;
      tmo_q      <= tmo_d;
      rxd_s1     <= rxd_line;
      rxd_s2     <= rxd_s1;
      rdf_prev_q <= rdf;
    end
  end

  // storage
  logic              push_req, push, pop, full, empty;
  logic [DATA_W-1:0] fifo_rdata;
  logic [CNT_W-1:0]  count, trig;

  assign push_req = rx_valid & en_q;
  assign pop      = reg_rd && (reg_addr == A_DATA) && !empty;
  assign push     = push_req & (~full | pop);
  assign trig     = CNT_W'(trig_level(tsel_q));

  rxfs_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (push),
    .pop   (pop),
    .wdata (rx_data),
    .rdata (fifo_rdata),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  // idle timer for the data-ready flag
  logic tmo_fire;
  rxfs_idle_timer #(.TMO_W(TMO_W)) u_idle (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (push),
    .tick    (char_tick),
    .tmo     (tmo_q),
    .fire    (tmo_fire)
  );

  // status flags: index 0 threshold, 1 error, 2 break, 3 data ready
  localparam int NSTAT = 4;
  logic [NSTAT-1:0] st_set, st_flag, st_clr;
  logic             st_rd, st_wr, ln_rd, ln_wr, orer, orer_clr;

  assign st_rd = reg_rd && (reg_addr == A_STAT);
  assign st_wr = reg_wr && (reg_addr == A_STAT);
  assign ln_rd = reg_rd && (reg_addr == A_LINE);
  assign ln_wr = reg_wr && (reg_addr == A_LINE);

  assign st_set[0] = (count >= trig);
  assign st_set[1] = push_req & (rx_frame_err | rx_parity_err);
  assign st_set[2] = push_req & rx_break;
  assign st_set[3] = tmo_fire & ~empty & (count < trig);

  generate
    for (genvar i = 0; i < NSTAT; i++) begin : g_stat
      rxfs_flag_cell #(.SET_WINS(i != 0)) u_cell (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .set    (st_set[i]),
        .rd_stb (st_rd),
        .wr_stb (st_wr),
        .wr_bit (reg_wdata[i]),
        .flag   (st_flag[i]),
        .clr    (st_clr[i])
      );
    end
  endgenerate

  rxfs_flag_cell #(.SET_WINS(1'b1)) u_orer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set    (push_req & full & ~pop),
    .rd_stb (ln_rd),
    .wr_stb (ln_wr),
    .wr_bit (reg_wdata[0]),
    .flag   (orer),
    .clr    (orer_clr)
  );

  assign rdf = st_flag[0];
  assign rxi = rdf & ~rdf_prev_q;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[DATA_W-1:NSTAT], st_clr[NSTAT-1:1], orer_clr};

  // read mux
  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = empty ? '0 : fifo_rdata;
      A_STAT:  reg_rdata = DATA_W'(st_flag);
      A_LINE:  reg_rdata = {rxd_s2, {(DATA_W-2){1'b0}}, orer};
      A_COUNT: reg_rdata = DATA_W'(count);
      A_CTRL:  reg_rdata = {tmo_q, tsel_q, en_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxfs_checker.sv
module rxfs_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] trig,
  input logic             en,
  input logic             pop,
  input logic             push_req,
  input logic             full,
  input logic             rdf,
  input logic             rdf_clr,
  input logic             rxi,
  input logic             orer,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [7:0]       reg_wdata
);
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_disabled_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !pop) |=> $stable(count));

  p_rdf_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= trig && !rdf_clr) |=> rdf);

  p_rdf_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdf) |-> $past(reg_wr && reg_addr == 3'd1 && !reg_wdata[0]));

  p_rxi_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rxi |-> (rdf && !$past(rdf)));

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop) |=> (orer && $stable(count)));
endmodule

bind uart_rx_fifo_status rxfs_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .count     (count),
  .trig      (trig),
  .en        (en_q),
  .pop       (pop),
  .push_req  (push_req),
  .full      (full),
  .rdf       (rdf),
  .rdf_clr   (st_clr[0]),
  .rxi       (rxi),
  .orer      (orer),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/tb_uart_rx_fifo_status.sv
module tb_uart_rx_fifo_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_frame_err = 1'b0, rx_parity_err = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       char_tick = 1'b0, rxd_line = 1'b1;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rxi;

  int n_chk = 0, n_bad = 0, rxi_seen = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_rx_fifo_status dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err), .rx_break(rx_break),
    .char_tick(char_tick), .rxd_line(rxd_line), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxi(rxi)
  );

  always @(negedge clk) if (rst_n && rxi) rxi_seen++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b, input logic fe, input logic pe, input logic brk);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_frame_err = fe; rx_parity_err = pe; rx_break = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0; rx_break = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a;
    #1 v = reg_rdata;
  endtask

  // write, then sample the same address one edge later
  task automatic wr(input logic [2:0] a, input logic [7:0] d, output logic [7:0] post);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    #1 post = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk); char_tick = 1'b1;
    @(negedge clk); char_tick = 1'b0;
  endtask

  function automatic int trig_of(input int sel);
    case (sel) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] q[$];
    logic er_m, brk_m, orer_m, rdf_m;
    int r0;
    r0 = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    peek(3'd1, v); check("R1 status", v, 0);
    peek(3'd2, v); check("R1 line", v & 8'h01, 0);
    peek(3'd3, v); check("R1 count", v, 0);
    peek(3'd4, v); check("R1 ctrl", v, 0);
    check("R1 rxi", rxi, 0);

    // R3 disabled: bytes ignored
    push(8'h11, 1'b1, 1'b0, 1'b1);
    peek(3'd3, v); check("R3 count", v, 0);
    peek(3'd1, v); check("R3 flags", v, 0);

    // R11 empty read
    rd(3'd0, v); check("R11 empty data", v, 0);
    peek(3'd3, v); check("R11 count", v, 0);

    // random phase: trigger 8, compare against a queue model (R2 R4 R7 R8)
    wr(3'd4, 8'h05, v);
    er_m = 0; brk_m = 0; orer_m = 0; rdf_m = 0;
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 10;
      if (op < 6) begin
        logic [7:0] b = 8'($urandom);
        logic fe = ($urandom % 16) == 0;
        logic pe = ($urandom % 16) == 0;
        logic bk = ($urandom % 32) == 0;
        push(b, fe, pe, bk);
        er_m |= fe | pe; brk_m |= bk;
        if (q.size() == 16) orer_m = 1; else q.push_back(b);
        if (q.size() >= trig_of(2)) rdf_m = 1;
      end else begin
        rd(3'd0, v);
        if (q.size() == 0) check("R11 random empty read", v, 0);
        else check("R2 random data order", v, q.pop_front());
      end
      peek(3'd3, v); check("R2 random count", v, q.size());
      peek(3'd1, v); check("R4 R7 random status", v, {4'b0, 1'b0, brk_m, er_m, rdf_m});
      peek(3'd2, v); check("R8 random overrun", v & 8'h01, orer_m);
    end

    // R4 / R6 / R5 threshold with trigger 4
    do_reset();
    wr(3'd4, 8'h03, v);
    r0 = rxi_seen;
    for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i), 0, 0, 0);
    peek(3'd1, v); check("R4 below trigger", v & 8'h01, 0);
    push(8'hA3, 0, 0, 0);
    peek(3'd1, v); check("R4 at trigger", v & 8'h01, 1);
    check("R6 one pulse", rxi_seen - r0, 1);
    wr(3'd1, 8'h00, v); check("R5 zero write without read", v & 8'h01, 1);
    rd(3'd1, v);
    wr(3'd1, 8'h00, v); check("R5 clear after read", v & 8'h01, 0);
    peek(3'd1, v); check("R5 reassert at level", v & 8'h01, 1);
    check("R6 second pulse", rxi_seen - r0, 2);
    for (int i = 0; i < 4; i++) begin
      rd(3'd0, v); check("R2 directed order", v, 8'hA0 + i);
    end
    rd(3'd1, v);
    wr(3'd1, 8'h00, v);
    peek(3'd1, v); check("R5 stays clear when empty", v & 8'h01, 0);

    // R7 error and break flags, trigger 1
    do_reset();
    wr(3'd4, 8'h01, v);
    push(8'h21, 1'b1, 1'b0, 1'b0);
    peek(3'd1, v); check("R7 framing sets error", v & 8'h02, 8'h02);
    rd(3'd1, v);
    wr(3'd1, 8'h01, v); check("R7 error cleared, threshold kept", v & 8'h03, 8'h01);
    push(8'h22, 1'b0, 1'b1, 1'b0);
    peek(3'd1, v); check("R7 parity sets error", v & 8'h02, 8'h02);
    push(8'h00, 1'b0, 1'b0, 1'b1);
    peek(3'd1, v); check("R7 break flag", v & 8'h04, 8'h04);

    // R8 overrun with trigger 14
    do_reset();
    wr(3'd4, 8'h07, v);
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i), 0, 0, 0);
    peek(3'd3, v); check("R2 full count", v, 16);
    peek(3'd1, v); check("R4 trigger 14", v & 8'h01, 1);
    push(8'hEE, 0, 0, 0);
    peek(3'd2, v); check("R8 overrun flag", v & 8'h01, 1);
    peek(3'd3, v); check("R8 count held", v, 16);
    for (int i = 0; i < 16; i++) begin
      rd(3'd0, v); check("R8 contents intact", v, 8'h40 + i);
    end
    rd(3'd2, v);
    wr(3'd2, 8'h00, v); check("R8 overrun cleared", v & 8'h01, 0);

    // R9 idle timeout: trigger 8, timeout 3
    do_reset();
    wr(3'd4, 8'h1D, v);
    push(8'h51, 0, 0, 0);
    push(8'h52, 0, 0, 0);
    tick(); tick();
    peek(3'd1, v); check("R9 before timeout", v & 8'h08, 0);
    tick();
    peek(3'd1, v); check("R9 at timeout", v & 8'h08, 8'h08);

    // R10 line level
    @(negedge clk); rxd_line = 1'b0;
    repeat (3) @(negedge clk);
    peek(3'd2, v); check("R10 line low", v[7], 0);
    rxd_line = 1'b1;
    repeat (3) @(negedge clk);
    peek(3'd2, v); check("R10 line high", v[7], 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule